// File: doc/BRIEF.md
# Return Address Stack with Interrupt Gating

This block is the hardware return-address store of a small 8-bit microcontroller core. A subroutine call, or the acknowledge of an interrupt, saves the current program counter. A return, from a subroutine or from an interrupt, takes the most recent saved value back. Software has no path to the stored values or to the internal index. The block keeps the values in a ring of slots and counts how many are live. A full flag and an empty flag report that count.

The block also decides when a pending interrupt request may be taken. A request that arrives while every level is in use is not acknowledged. It waits until a return has freed a level. A call made while the stack is full is still accepted: the new address replaces the oldest one, so the most recent return addresses survive. The program counter, instruction decode and interrupt priority logic sit outside this block.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, with all strobes low, `empty` is 1, and `full`, `irq_ack` and `underflow` are 0.
- R2: `push_call` stores `pc_in`. While `pop_ret` is high, `pop_addr` shows the most recently stored live value in the same cycle, and the pop removes it, so values come back in last-in, first-out order.
- R3: Occupancy starts at 0. Each accepted push raises it by one, up to 8, and each pop on a non-empty stack lowers it by one. `full` is high exactly at 8 and `empty` is high exactly at 0.
- R4: A push at occupancy 8 is still stored. The oldest entry is lost and occupancy stays 8. The next 8 pops return the 8 newest values, newest first, and the stack is then empty.
- R5: With a request on `irq_req`, the stack not full, and neither `push_call` nor `pop_ret` high, `irq_ack` is high in the same cycle and `pc_in` is pushed.
- R6: While `full` is high, `irq_ack` stays low whatever `irq_req` does. A request still held in the cycle after a pop that left the stack below 8 is acknowledged.
- R7: Storage is a ring of 8 slots reset to 0. A write index starts at slot 0, moves up one slot (mod 8) on each push and down one slot on each pop from a non-empty stack. `pop_addr` always shows the slot just below the write index. A pop on an empty stack leaves the index and the occupancy unchanged and raises `underflow` for that cycle only.
- R8: In a cycle where `push_call` or `pop_ret` is high, `irq_ack` is low. The request is taken in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_call | input | 1 | Subroutine call: push `pc_in` |
| pop_ret | input | 1 | Return of either kind: pop the top entry |
| irq_req | input | 1 | Pending, unmasked interrupt request |
| pc_in | input | PC_W (13) | Program counter value to save |
| pop_addr | output | PC_W (13) | Top entry, the restore value during a pop |
| irq_ack | output | 1 | Interrupt acknowledge, gated by occupancy |
| full | output | 1 | All levels in use |
| empty | output | 1 | No live entry |
| underflow | output | 1 | Pulse: pop on an empty stack |

## Verification
The assertions assume that `push_call` and `pop_ret` are never high in the same cycle. That combination is an illegal input: the block resolves it in favour of the pop, but the properties about occupancy take no account of it. They also assume that the interrupt controller holds `irq_req` until it sees `irq_ack`. The stimulus drives every input on the falling edge, and it issues at most one of call or return in any cycle. It can raise the interrupt request together with either strobe, or on its own. A request is withdrawn only after the cycle in which the bench has checked the acknowledge.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Next slot upward in a ring of 'depth' slots
  function automatic int unsigned ring_up(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Next slot downward in a ring of 'depth' slots
  function automatic int unsigned ring_down(int unsigned idx, int unsigned depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction

  // Occupancy after one cycle: pop wins, push saturates at depth
  function automatic int unsigned occ_next(int unsigned occ, bit push, bit pop,
                                           int unsigned depth);
    if (pop)  return (occ == 0) ? 0 : occ - 1;
    if (push) return (occ >= depth) ? depth : occ + 1;
    return occ;
  endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
  parameter  int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] top_idx,
  output logic             wr_en,
  output logic             full,
  output logic             empty,
  output logic             underflow
);
  import ras_pkg::*;

  logic [CNT_W-1:0] occ_q;
  logic [IDX_W-1:0] idx_q;
  logic             push_fire;
  logic             pop_live;

  // Named events for the checks below
  assign push_fire = push_req & ~pop_req;
  assign pop_live  = pop_req & ~empty;
  assign full      = (occ_q == CNT_W'(DEPTH));
  assign empty     = (occ_q == '0);
  assign underflow = pop_req & empty;
  assign wr_en     = push_fire;
  assign wr_idx    = idx_q;
  assign top_idx   = IDX_W'(ring_down(int'(idx_q), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      idx_q <= '0;
    end else begin
      occ_q <= CNT_W'(occ_next(int'(occ_q), push_fire, pop_req, DEPTH));
      if (pop_live)
        idx_q <= IDX_W'(ring_down(int'(idx_q), DEPTH));
      else if (push_fire)
        idx_q <= IDX_W'(ring_up(int'(idx_q), DEPTH));
    end
  end

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(DEPTH));

  // R3
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire && !full |=> occ_q == $past(occ_q) + 1'b1);

  // R4
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire && full |=> full);

  // R3
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_live |=> occ_q == $past(occ_q) - 1'b1);

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> empty && idx_q == $past(idx_q));

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter  int DEPTH = 8,
  parameter  int PC_W  = 13,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_data
);
  logic [PC_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic full,
  input  logic push_call,
  input  logic pop_ret,
  output logic irq_ack
);
  logic slot_free;
  logic bus_idle;

  assign slot_free = ~full;
  assign bus_idle  = ~push_call & ~pop_ret;
  assign irq_ack   = irq_req & slot_free & bus_idle;

  // R6
  held_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !irq_ack);

  // R8
  defer_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_call || pop_ret) |-> !irq_ack);

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter  int DEPTH = 8,
  parameter  int PC_W  = 13,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_call,
  input  logic            pop_ret,
  input  logic            irq_req,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] pop_addr,
  output logic            irq_ack,
  output logic            full,
  output logic            empty,
  output logic            underflow
);
  logic             push_any;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] top_idx;

  assign push_any = push_call | irq_ack;

  ras_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .full(full),
    .push_call(push_call), .pop_ret(pop_ret), .irq_ack(irq_ack)
  );

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_req(push_any), .pop_req(pop_ret),
    .wr_idx(wr_idx), .top_idx(top_idx), .wr_en(wr_en),
    .full(full), .empty(empty), .underflow(underflow)
  );

  ras_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(pc_in), .rd_idx(top_idx), .rd_data(pop_addr)
  );

  // R5
  ack_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !empty && pop_addr == $past(pc_in));

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> empty && !full);

  // R7
  underflow_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> empty && pop_ret);

endmodule

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
  localparam int D = 8;
  localparam int W = 13;

  logic clk = 0;
  logic rst_n = 0;
  logic push_call = 0, pop_ret = 0, irq_req = 0;
  logic [W-1:0] pc_in = '0;
  logic [W-1:0] pop_addr;
  logic irq_ack, full, empty, underflow;

  int checks = 0, errors = 0;
  int mdl [D];
  int widx = 0, cnt = 0;
  string pop_tag = "R2";

  always #5 clk = ~clk;

  ret_addr_stack u_dut (
    .clk(clk), .rst_n(rst_n), .push_call(push_call), .pop_ret(pop_ret),
    .irq_req(irq_req), .pc_in(pc_in), .pop_addr(pop_addr), .irq_ack(irq_ack),
    .full(full), .empty(empty), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, check combinational results, then clock.
  task automatic step(input bit p, input bit r, input bit q, input int pc);
    bit exp_ack;
    @(negedge clk);
    push_call = p; pop_ret = r; irq_req = q; pc_in = W'(pc);
    #1;
    exp_ack = q && (cnt != D) && !p && !r;
    chk(full == (cnt == D), "R3", full, cnt == D);
    chk(empty == (cnt == 0), "R3", empty, cnt == 0);
    if (q) chk(irq_ack == exp_ack, (p || r) ? "R8" : (cnt == D ? "R6" : "R5"),
               irq_ack, exp_ack);
    else   chk(irq_ack == 1'b0, "R5", irq_ack, 0);
    chk(underflow == (r && cnt == 0), "R7", underflow, r && cnt == 0);
    if (r) chk(int'(pop_addr) == mdl[(widx + D - 1) % D],
               (cnt == 0) ? "R7" : pop_tag, pop_addr, mdl[(widx + D - 1) % D]);
    if (r) begin
      if (cnt > 0) begin widx = (widx + D - 1) % D; cnt--; end
    end else if (p || exp_ack) begin
      mdl[widx] = pc % (1 << W);
      widx = (widx + 1) % D;
      if (cnt < D) cnt++;
    end
    @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    chk(empty == 1'b1, "R1", empty, 1);
    chk(full == 1'b0, "R1", full, 0);
    chk(irq_ack == 1'b0, "R1", irq_ack, 0);
    chk(underflow == 1'b0, "R1", underflow, 0);
    @(posedge clk);

    // R2/R3/R7: every fill level, drained one past empty
    for (int n = 0; n <= D; n++) begin
      for (int i = 0; i < n; i++) step(1, 0, 0, n * 97 + i * 13 + 5);
      for (int i = 0; i <= n; i++) step(0, 1, 0, 0);
    end

    // R4: overflow by 1..8 extra calls
    pop_tag = "R4";
    for (int x = 1; x <= D; x++) begin
      for (int i = 0; i < D + x; i++) step(1, 0, 0, 4000 + x * 211 + i * 7);
      for (int i = 0; i <= D; i++) step(0, 1, 0, 0);
    end
    pop_tag = "R2";

    // R5: interrupts taken from empty and partial levels
    for (int i = 0; i < 5; i++) step(0, 0, 1, 6000 + i);
    step(0, 0, 0, 0);
    // R8: request together with call, then with return
    step(1, 0, 1, 7001);
    step(0, 1, 1, 0);
    step(0, 0, 1, 7002);

    // R6: fill, hold request while full, free one level
    while (cnt < D) step(1, 0, 0, 7100 + cnt);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 7200 + i);
    step(0, 1, 1, 0);
    step(0, 0, 1, 7300);
    step(0, 0, 1, 7301);
    while (cnt > 0) step(0, 1, 0, 0);
    step(0, 1, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule